// File: doc/BRIEF.md
# Wiper Latch and Register Bank

This block keeps the state of one 64-tap digital potentiometer. A 6-bit wiper latch picks the active tap. Four 6-bit data registers hold saved positions. A command decoder elsewhere in the chip presents one command per cycle. The block can:

- read or write the latch or a selected register;
- copy between a register and the latch;
- step the wiper one tap up or down.

The output is a 64-bit one-hot tap-select vector that drives the switch array.

Register writes stand in for nonvolatile writes. A copy from the latch into a register, or a direct register write, starts a busy period. The period lasts a set number of clock cycles, and the bank accepts no command until it ends. A write-protect input that is active low blocks these nonvolatile writes. When a write is blocked, the register keeps its value and no busy period starts. Writes to the latch are always allowed.

At reset the registers load their initial contents, and the latch recalls register 0. The wiper therefore comes up at a stored position.

Top module: `wiper_bank`

## Requirements
- R1: After reset, `busy` is low, `rd_data` is 0, and the wiper sits at the initial value of register 0, which is tap 40 by default.
- R2: `tap_sel` has exactly one bit set at all times, and the index of that bit is the latch value.
- R3: The latch commands work as follows, and neither starts a busy period:
  - Op 2 (write latch) loads `cmd_data` into the latch; `tap_sel` shows the new tap in the next cycle.
  - Op 1 (read latch) puts the latch value on `rd_data` in the next cycle.
- R4: When `wp_n` is high, op 4 (write register) stores `cmd_data` into the register selected by `cmd_sel`. `busy` is then high for exactly WR_CYCLES cycles, starting in the next cycle. Op 3 (read register) returns the selected register's value on `rd_data` in the next cycle.
- R5: When `wp_n` is low, op 4 and op 6 leave every register unchanged and do not raise `busy`. Op 2 still updates the latch.
- R6: Op 5 copies the selected register into the latch without raising `busy`.
- R7: When `wp_n` is high, op 6 copies the latch into the selected register and starts a busy period of WR_CYCLES cycles.
- R8: Op 7 steps the wiper one tap:
  - With `cmd_data[0]` = 1 it moves up one tap, and at tap 63 it stays put.
  - With `cmd_data[0]` = 0 it moves down one tap, and at tap 0 it stays put.
- R9: While `busy` is high, every command is ignored. This covers op 0 (no operation) through op 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Operation code (see requirements) |
| cmd_sel | input | 2 | Data register select |
| cmd_data | input | 6 | Write data; bit 0 sets the step direction |
| wp_n | input | 1 | Write protect; low blocks nonvolatile writes |
| rd_data | output | 6 | Result of the last read command |
| busy | output | 1 | A nonvolatile write cycle is in progress |
| tap_sel | output | 64 | One-hot tap switch enables |

## Verification
The directed part of the test does three things:

- It drives the wiper into both end taps and steps outward. This separates saturation from wraparound.
- It issues register writes with write protect low and with it high. This separates a blocked write from an accepted one.
- It issues commands while a write cycle is running. This shows whether busy masking is in place.

The random part runs a long sequence with a mix of:

- valid and idle cycles;
- all register selects;
- protect levels that change from command to command.

That mix exposes any mistake in register indexing, in how the busy counter reloads, or in which operations count as nonvolatile.

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int TAPS      = 64,
  parameter int NREG      = 4,
  parameter int WR_CYCLES = 1_000_000,
  parameter int W         = $clog2(TAPS),
  parameter int SW        = $clog2(NREG),
  parameter logic [NREG*W-1:0] INIT_REGS = {6'd60, 6'd17, 6'd5, 6'd40}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [SW-1:0]   cmd_sel,
  input  logic [W-1:0]    cmd_data,
  input  logic            wp_n,
  output logic [W-1:0]    rd_data,
  output logic            busy,
  output logic [TAPS-1:0] tap_sel
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] OP_RDL = 3'd1, OP_WRL = 3'd2, OP_RDR = 3'd3, OP_WRR = 3'd4,
                         OP_R2L = 3'd5, OP_L2R = 3'd6, OP_STEP = 3'd7;

  logic [W-1:0]  regs [NREG];
  logic [W-1:0]  latch;
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= INIT_REGS[i*W +: W];
      latch   <= INIT_REGS[W-1:0];
      cnt     <= '0;
      rd_data <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_RDL: rd_data <= latch;
        OP_WRL: latch <= cmd_data;
        OP_RDR: rd_data <= regs[cmd_sel];
        OP_WRR: if (wp_n) begin
                  regs[cmd_sel] <= cmd_data;
                  cnt <= CW'(WR_CYCLES);
                end
        OP_R2L: latch <= regs[cmd_sel];
        OP_L2R: if (wp_n) begin
                  regs[cmd_sel] <= latch;
                  cnt <= CW'(WR_CYCLES);
                end
        OP_STEP: begin
          if (cmd_data[0] && latch != W'(TAPS - 1)) latch <= latch + 1'b1;
          else if (!cmd_data[0] && latch != '0)      latch <= latch - 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_sel[g] = (latch == W'(g));
  end
endmodule

module wiper_bank_chk #(
  parameter int TAPS = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic [5:0]      cmd_data,
  input logic            wp_n,
  input logic            busy,
  input logic [TAPS-1:0] tap_sel
);
  wire go  = cmd_valid && !busy;
  wire nvw = go && (cmd_op == 3'd4 || cmd_op == 3'd6);

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1); // R2
  AST_NV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nvw && wp_n |=> busy); // R4
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    nvw && !wp_n |=> !busy); // R5
  AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == 3'd7 && cmd_data[0] && tap_sel[TAPS-1] |=> tap_sel[TAPS-1]); // R8
  AST_BOT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == 3'd7 && !cmd_data[0] && tap_sel[0] |=> tap_sel[0]); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tap_sel)); // R9
endmodule

bind wiper_bank wiper_bank_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .wp_n(wp_n), .busy(busy), .tap_sel(tap_sel));

// File: tb/sim_wiper_bank.sv
`timescale 1ns/1ps
module sim_wiper_bank;
  localparam int WRC = 12;
  logic clk = 0, rst_n = 0, cmd_valid = 0, wp_n = 1;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_sel = 0;
  logic [5:0] cmd_data = 0;
  logic [5:0] rd_data;
  logic busy;
  logic [63:0] tap_sel;
  int runs = 0, fails = 0;
  bit done = 0;

  logic [5:0] mreg [4];
  logic [5:0] mlat, mrd;
  int mcnt;

  always #2.5 clk = ~clk;

  wiper_bank #(.WR_CYCLES(WRC)) u0 (.*);

  task automatic chk(string tag);
    runs++;
    if (tap_sel !== (64'd1 << mlat)) begin
      fails++; $display("FAIL %s tap_sel act=%h exp=%h", tag, tap_sel, 64'd1 << mlat);
    end
    runs++;
    if (busy !== (mcnt != 0)) begin
      fails++; $display("FAIL %s busy act=%0b exp=%0b", tag, busy, mcnt != 0);
    end
    runs++;
    if (rd_data !== mrd) begin
      fails++; $display("FAIL %s rd_data act=%0d exp=%0d", tag, rd_data, mrd);
    end
  endtask

  task automatic step(logic v, logic [2:0] op, logic [1:0] sel, logic [5:0] d, logic wp, string tag);
    cmd_valid = v; cmd_op = op; cmd_sel = sel; cmd_data = d; wp_n = wp;
    if (mcnt != 0) mcnt--;
    else if (v) case (op)
      3'd1: mrd = mlat;
      3'd2: mlat = d;
      3'd3: mrd = mreg[sel];
      3'd4: if (wp) begin mreg[sel] = d; mcnt = WRC; end
      3'd5: mlat = mreg[sel];
      3'd6: if (wp) begin mreg[sel] = mlat; mcnt = WRC; end
      3'd7: if (d[0] && mlat != 63) mlat++; else if (!d[0] && mlat != 0) mlat--;
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 0;
    chk(tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mreg[0] = 40; mreg[1] = 5; mreg[2] = 17; mreg[3] = 60;
    mlat = 40; mrd = 0; mcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1");
    step(1, 3'd1, 0, 0, 1, "R3");
    step(1, 3'd2, 0, 63, 1, "R3");
    step(1, 3'd7, 0, 1, 1, "R8");
    step(1, 3'd7, 0, 0, 1, "R8");
    step(1, 3'd2, 0, 0, 1, "R3");
    step(1, 3'd7, 0, 0, 1, "R8");
    step(1, 3'd7, 0, 1, 1, "R8");
    step(1, 3'd4, 2, 33, 1, "R4");
    step(1, 3'd2, 0, 9, 1, "R9");
    step(1, 3'd3, 2, 0, 1, "R9");
    for (int i = 0; i < WRC; i++) step(0, 0, 0, 0, 1, "R4");
    step(1, 3'd3, 2, 0, 1, "R4");
    step(1, 3'd4, 1, 50, 0, "R5");
    step(1, 3'd3, 1, 0, 0, "R5");
    step(1, 3'd6, 0, 0, 0, "R5");
    step(1, 3'd3, 0, 0, 0, "R5");
    step(1, 3'd2, 0, 21, 0, "R5");
    step(1, 3'd5, 2, 0, 1, "R6");
    step(1, 3'd2, 0, 11, 1, "R7");
    step(1, 3'd6, 3, 0, 1, "R7");
    for (int i = 0; i < WRC; i++) step(0, 0, 0, 0, 1, "R7");
    step(1, 3'd3, 3, 0, 1, "R7");
    for (int i = 0; i < 2000; i++)
      step(($urandom % 3) != 0, 3'($urandom), 2'($urandom), 6'($urandom),
           ($urandom % 4) != 0, "R2");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule